// File: doc/BRIEF.md
# Serial Bus PHY Register Bank with Bus Reset Control

This block is the small register bank on the PHY side of a serial bus node. The link layer reaches it through a plain strobe, address and data access port. The bank stores the root hold-off flag, the 6-bit gap count, a set of interrupt status flags and a pair of enhancement enable bits. It turns writes to its two reset-request bits into one-cycle requests for a long bus reset or for an arbitrated short bus reset.

The gap count shares its register with the long-reset bit and the root hold-off flag, so one write sets all three at once. A completed-reset input tells the bank each time a bus reset finishes. If two resets complete and no gap count write falls between them, the gap count returns to its default of 3F hex.

The short-reset bit sits in a separate register. Software can therefore start a reset without touching the gap count or the root hold-off flag.

Top module: `phyreg_bank`

## Requirements
- R1: After reset the gap count is 3F hex. The root hold-off flag, the enhancement enables, the interrupt flags, both reset requests and the read data are all 0.
- R2: A write to address 1 loads bit 7 into the root hold-off flag and bits 5:0 into the gap count in the same cycle. Both are visible on the outputs one cycle after the write strobe.
- R3: A write to address 1 with bit 6 set drives `long_rst_req` high for exactly the one cycle after the write. Bit 6 of address 1 always reads back as 0.
- R4: A write to address 5 with bit 6 set drives `short_rst_req` high for exactly the one cycle after the write, and `long_rst_req` stays low. Bit 6 of address 5 always reads back as 0.
- R5: A write to address 5 leaves the gap count and the root hold-off flag unchanged. It loads write data bits 1:0 into the enhancement enables.
- R6: Interrupt flag i is read at address 5, bit 4+i, for i = 0 and 1. A cycle with `hw_evt[i]` high sets the flag, and the flag stays set until a write to address 5 with bit 4+i set. Writing 0 to that bit leaves the flag unchanged. If an event and a clearing write arrive in the same cycle, the flag stays set.
- R7: A second `reset_done` pulse with no address-1 write since the first forces the gap count to 3F hex in the next cycle. A single pulse leaves the gap count unchanged.
- R8: A write to address 1 restarts the count of completed resets. This holds even when the write and a `reset_done` pulse fall in the same cycle, in which case the written gap count wins.
- R9: `rd_data` shows the addressed register one cycle after `rd_en` and holds its value between reads. Address 1 reads as {root hold-off, 0, gap count}. Address 5 reads as {00, interrupt flags, 00, enables}. All other addresses read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid one cycle after `rd_en` |
| reset_done | input | 1 | One-cycle pulse when a bus reset completes |
| hw_evt | input | 2 | Hardware events that set the interrupt flags |
| long_rst_req | output | 1 | One-cycle request for a long bus reset |
| short_rst_req | output | 1 | One-cycle request for an arbitrated short bus reset |
| gap_count | output | 6 | Current gap count |
| root_holdoff | output | 1 | Current root hold-off flag |
| enh_en | output | 2 | Current enhancement enables |

## Verification
Every result of this block is registered once. Register values, both reset-request pulses, the gap-count revert and read data all appear one edge after the strobe or pulse that causes them.

The bench drives each stimulus at a falling edge and holds it across one rising edge. It samples at the following falling edge, where the result is due. For the reset-request pulses it samples one more falling edge later to confirm the pulse is already gone.

Revert checks alternate `reset_done` pulses with address-1 writes, so that the count restart is observed through the gap count output alone.

// File: rtl/phyreg_pkg.sv
package phyreg_pkg;
  localparam int DW       = 8;
  localparam int AW       = 4;
  localparam int GAP_W    = 6;
  localparam int NUM_IRQ  = 2;
  localparam int NUM_ENH  = 2;
  localparam int IRQ_LSB  = 4;
  localparam int RHB_BIT  = 7;
  localparam int LREQ_BIT = 6;
  localparam int SREQ_BIT = 6;
  localparam logic [AW-1:0] ADDR_CORE = 4'd1;
  localparam logic [AW-1:0] ADDR_EXT  = 4'd5;
  typedef logic [DW-1:0] byte_t;
endpackage

// File: rtl/phyreg_core.sv
module phyreg_core
  import phyreg_pkg::*;
#(
  parameter logic [GAP_W-1:0] GAP_DEFAULT = 6'h3F,
  parameter int               REVERTS     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  byte_t            wdata,
  input  logic             reset_done,
  output logic [GAP_W-1:0] gap_q,
  output logic             rhb_q,
  output logic             long_req_q
);
  localparam int CNT_W = $clog2(REVERTS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REVERTS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic [GAP_W-1:0] gap_nx;
  logic             rhb_nx, req_nx;

  always_comb begin
    gap_nx = gap_q;
    rhb_nx = rhb_q;
    cnt_nx = cnt_q;
    req_nx = 1'b0;
    if (wr_en) begin
      rhb_nx = wdata[RHB_BIT];
      gap_nx = wdata[GAP_W-1:0];
      req_nx = wdata[LREQ_BIT];
      cnt_nx = '0;
    end else if (reset_done) begin
      if (cnt_q == LAST) begin
        gap_nx = GAP_DEFAULT;
        cnt_nx = '0;
      end else begin
        cnt_nx = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q      <= GAP_DEFAULT;
      rhb_q      <= 1'b0;
      cnt_q      <= '0;
      long_req_q <= 1'b0;
    end else begin
      gap_q      <= gap_nx;
      rhb_q      <= rhb_nx;
      cnt_q      <= cnt_nx;
      long_req_q <= req_nx;
    end
  end

  // R8: a write always restarts the completed-reset count
  a_r8_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cnt_q == '0));
  // R7: the count never passes the revert threshold
  a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R7: a completion at the threshold lands on the default gap count
  a_r7_revert: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_done && !wr_en && cnt_q == LAST) |=> (gap_q == GAP_DEFAULT));
endmodule

// File: rtl/phyreg_ext.sv
module phyreg_ext
  import phyreg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NUM_IRQ-1:0] clr_bits,
  input  logic [NUM_ENH-1:0] enh_bits,
  input  logic               sreq_bit,
  input  logic [NUM_IRQ-1:0] hw_evt,
  output logic [NUM_IRQ-1:0] irq_q,
  output logic [NUM_ENH-1:0] enh_q,
  output logic               short_req_q
);
  logic [NUM_IRQ-1:0] irq_nx;
  logic [NUM_ENH-1:0] enh_nx;
  logic               sreq_nx;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    always_comb irq_nx[i] = (irq_q[i] & ~(wr_en & clr_bits[i])) | hw_evt[i];

    // R6: a set flag stays set unless a clearing write arrives
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q[i] && !(wr_en && clr_bits[i])) |=> irq_q[i]);
    // R6: an event always leaves the flag set
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      hw_evt[i] |=> irq_q[i]);
  end

  always_comb begin
    enh_nx  = wr_en ? enh_bits : enh_q;
    sreq_nx = wr_en & sreq_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q       <= '0;
      enh_q       <= '0;
      short_req_q <= 1'b0;
    end else begin
      irq_q       <= irq_nx;
      enh_q       <= enh_nx;
      short_req_q <= sreq_nx;
    end
  end
endmodule

// File: rtl/phyreg_bank.sv
module phyreg_bank
  import phyreg_pkg::*;
#(
  parameter logic [GAP_W-1:0] GAP_DEFAULT = 6'h3F,
  parameter int               REVERTS     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wr_data,
  output logic [DW-1:0]      rd_data,
  input  logic               reset_done,
  input  logic [NUM_IRQ-1:0] hw_evt,
  output logic               long_rst_req,
  output logic               short_rst_req,
  output logic [GAP_W-1:0]   gap_count,
  output logic               root_holdoff,
  output logic [NUM_ENH-1:0] enh_en
);
  logic [1:0]         rst_pipe;
  logic               rst_i;
  logic               wr_core, wr_ext;
  logic [NUM_IRQ-1:0] irq;
  byte_t              img_core, img_ext, rd_nx, rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  always_comb begin
    wr_core = wr_en && (addr == ADDR_CORE);
    wr_ext  = wr_en && (addr == ADDR_EXT);
  end

  phyreg_core #(.GAP_DEFAULT(GAP_DEFAULT), .REVERTS(REVERTS)) u_core (
    .clk        (clk),
    .rst_n      (rst_i),
    .wr_en      (wr_core),
    .wdata      (wr_data),
    .reset_done (reset_done),
    .gap_q      (gap_count),
    .rhb_q      (root_holdoff),
    .long_req_q (long_rst_req)
  );

  phyreg_ext u_ext (
    .clk         (clk),
    .rst_n       (rst_i),
    .wr_en       (wr_ext),
    .clr_bits    (wr_data[IRQ_LSB +: NUM_IRQ]),
    .enh_bits    (wr_data[NUM_ENH-1:0]),
    .sreq_bit    (wr_data[SREQ_BIT]),
    .hw_evt      (hw_evt),
    .irq_q       (irq),
    .enh_q       (enh_en),
    .short_req_q (short_rst_req)
  );

  always_comb begin
    img_core                   = '0;
    img_core[RHB_BIT]          = root_holdoff;
    img_core[GAP_W-1:0]        = gap_count;
    img_ext                    = '0;
    img_ext[IRQ_LSB +: NUM_IRQ] = irq;
    img_ext[NUM_ENH-1:0]       = enh_en;
    rd_nx = rd_q;
    if (rd_en) begin
      if (addr == ADDR_CORE)     rd_nx = img_core;
      else if (addr == ADDR_EXT) rd_nx = img_ext;
      else                       rd_nx = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) rd_q <= '0;
    else        rd_q <= rd_nx;
  end
  assign rd_data = rd_q;

  // R3: a long request only follows an address-1 write with the request bit
  a_r3_long_source: assert property (@(posedge clk) disable iff (!rst_i)
    long_rst_req |-> $past(wr_core && wr_data[LREQ_BIT]));
  // R4: a short request only follows an address-5 write with the request bit
  a_r4_short_source: assert property (@(posedge clk) disable iff (!rst_i)
    short_rst_req |-> $past(wr_ext && wr_data[SREQ_BIT]));
  // R4: the two requests never coincide
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_i)
    !(long_rst_req && short_rst_req));
  // R5: an address-5 write keeps gap count and root hold-off
  a_r5_ext_keeps_core: assert property (@(posedge clk) disable iff (!rst_i)
    (wr_ext && !reset_done) |=> ($stable(gap_count) && $stable(root_holdoff)));
  // R9: read data only moves after a read strobe
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_i)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/sim_phyreg_bank.sv
module sim_phyreg_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, reset_done = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] hw_evt = '0;
  logic [7:0] rd_data;
  logic       long_rst_req, short_rst_req, root_holdoff;
  logic [5:0] gap_count;
  logic [1:0] enh_en;
  int checks = 0, errors = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  phyreg_bank u0 (.*);

  // entry: {is_write, req, addr, data_or_expected}
  localparam int NV = 15;
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 4'd2, 4'd1, 8'hA5}, {1'b0, 4'd2, 4'd1, 8'hA5},  // R2
    {1'b1, 4'd5, 4'd5, 8'h03}, {1'b0, 4'd5, 4'd5, 8'h03},  // R5
    {1'b0, 4'd5, 4'd1, 8'hA5},                             // R5
    {1'b1, 4'd2, 4'd1, 8'h1F}, {1'b0, 4'd2, 4'd1, 8'h1F},  // R2
    {1'b1, 4'd9, 4'd3, 8'hFF}, {1'b0, 4'd9, 4'd3, 8'h00},  // R9
    {1'b0, 4'd9, 4'd5, 8'h03},                             // R9
    {1'b1, 4'd5, 4'd5, 8'h00}, {1'b0, 4'd5, 4'd5, 8'h00},  // R5
    {1'b1, 4'd3, 4'd1, 8'h4A}, {1'b0, 4'd3, 4'd1, 8'h0A},  // R3
    {1'b0, 4'd9, 4'd1, 8'h0A}                              // R9
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic pulse_done();
    @(negedge clk); reset_done = 1'b1;
    @(negedge clk); reset_done = 1'b0;
  endtask

  task automatic pulse_evt(input logic [1:0] e);
    @(negedge clk); hw_evt = e;
    @(negedge clk); hw_evt = 2'b00;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 gap", {2'b0, gap_count}, 8'h3F);
    chk("R1 rhb/enh", {5'b0, root_holdoff, enh_en}, 8'h00);
    chk("R1 req", {6'b0, long_rst_req, short_rst_req}, 8'h00);
    chk("R1 rd_data", rd_data, 8'h00);
    do_read(4'd1, rv); chk("R1 read core", rv, 8'h3F);
    do_read(4'd5, rv); chk("R1 read ext", rv, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][16]) do_write(VEC[i][11:8], VEC[i][7:0]);
      else begin
        do_read(VEC[i][11:8], rv);
        chk($sformatf("R%0d vector %0d", VEC[i][15:12], i), rv, VEC[i][7:0]);
      end
    end

    // R3 long pulse timing
    do_write(4'd1, 8'hC4);
    chk("R3 long high", {7'b0, long_rst_req}, 8'h01);
    chk("R2 core outputs", {root_holdoff, 1'b0, gap_count}, 8'h84);
    @(negedge clk);
    chk("R3 long low", {7'b0, long_rst_req}, 8'h00);
    // R4 short pulse timing, R5 core untouched
    do_write(4'd5, 8'h40);
    chk("R4 short high, long low", {6'b0, long_rst_req, short_rst_req}, 8'h01);
    @(negedge clk);
    chk("R4 short low", {7'b0, short_rst_req}, 8'h00);
    chk("R5 core kept", {root_holdoff, 1'b0, gap_count}, 8'h84);
    do_read(4'd5, rv); chk("R4 bit reads 0", rv, 8'h00);

    // R6 interrupt flags
    pulse_evt(2'b01);
    do_read(4'd5, rv); chk("R6 set", rv, 8'h10);
    do_write(4'd5, 8'h00);
    do_read(4'd5, rv); chk("R6 write 0 keeps", rv, 8'h10);
    do_write(4'd5, 8'h10);
    do_read(4'd5, rv); chk("R6 write 1 clears", rv, 8'h00);
    pulse_evt(2'b10);
    @(negedge clk); wr_en = 1'b1; addr = 4'd5; wr_data = 8'h20; hw_evt = 2'b10;
    @(negedge clk); wr_en = 1'b0; hw_evt = 2'b00;
    do_read(4'd5, rv); chk("R6 set wins", rv, 8'h20);

    // R7 revert after two completions
    do_write(4'd1, 8'h12);
    pulse_done();
    chk("R7 one completion keeps", {2'b0, gap_count}, 8'h12);
    pulse_done();
    chk("R7 two completions revert", {2'b0, gap_count}, 8'h3F);

    // R8 write restarts count
    do_write(4'd1, 8'h15);
    pulse_done();
    do_write(4'd1, 8'h16);
    pulse_done();
    chk("R8 restart keeps", {2'b0, gap_count}, 8'h16);
    pulse_done();
    chk("R8 then revert", {2'b0, gap_count}, 8'h3F);
    pulse_done();
    @(negedge clk); wr_en = 1'b1; addr = 4'd1; wr_data = 8'h08; reset_done = 1'b1;
    @(negedge clk); wr_en = 1'b0; reset_done = 1'b0;
    chk("R8 write wins", {2'b0, gap_count}, 8'h08);
    pulse_done();
    chk("R8 count restarted", {2'b0, gap_count}, 8'h08);

    // R9 hold between reads
    do_read(4'd1, rv);
    repeat (3) @(negedge clk);
    chk("R9 hold", rd_data, 8'h08);

    // R1 reset mid-run
    do_write(4'd5, 8'h03);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 rerun gap", {2'b0, gap_count}, 8'h3F);
    chk("R1 rerun enh/rd", {enh_en, rd_data[5:0]}, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule